// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block makes the timing for an audio serial port. It runs on a fast master clock. When it is the clock master, it divides that clock by a programmable factor to make the serial bit clock. It then counts bit clocks with two independent frame dividers, one for the transmit frame clock and one for the receive frame clock. When it is the clock slave, the bit clock and the frame clock come in on pins. It passes them through a synchronizer, and the frame dividers sit idle.

A polarity control inverts the bit clock. This swaps which edge the serializer uses to launch data and which edge it uses to sample data. The serializer does not see the bit clock itself. It sees two one-cycle strobes in the master clock domain, one for the sample edge and one for the launch edge, together with the frame-clock levels. While neither direction is started, every output rests at its idle level. A reload pulse restarts all counters from zero. New divider values then take effect cleanly.

A common setup is 64 bit clocks per frame, which is two channels of 32 slots each. The bit divider is then set to mclk/(64*fs) - 1 and both frame dividers are set to 63.

Top module: `audio_clkgen`

## Requirements
- R1: While tx_start and rx_start are both low, no strobe is emitted. bclk_o equals bclk_inv, tx_frm_o and rx_frm_o are 0, and bclk_oe is 0. This holds from reset, and again within three clocks after both starts fall.
- R2: In master mode (role_slave=0) with bit_div=D, where D is at least 1, consecutive sample strobes are exactly D+1 clock cycles apart.
- R3: In master mode with bclk_inv=0, bclk_o is high for floor((D+1)/2) clock cycles of each D+1 cycle period, and low for the rest.
- R4: sample_stb is high for one cycle, in the first cycle in which bclk_o is high after being low. launch_stb is high for one cycle, in the first cycle in which bclk_o is low after being high. Both strobes are suppressed in the first cycle after a start.
- R5: In master mode with tx_div=T, where T is at least 1, tx_frm_o repeats every T+1 launch strobes. It stays low for floor((T+1)/2) launch strobes and high for the remainder. It changes only in the cycle after a launch strobe.
- R6: rx_frm_o follows the same rule as R5 with rx_div, independently of tx_div, and is driven from the same bit clock.
- R7: With bclk_inv=1, bclk_o is the inverse of the internal bit clock. In master mode it is then high for (D+1) - floor((D+1)/2) cycles per period, and the strobes of R4 follow the inverted output.
- R8: In slave mode (role_slave=1), each transition of bclk_pin produces exactly one strobe. With bclk_inv=0, a rise gives sample_stb and a fall gives launch_stb; with bclk_inv=1 this is swapped. bclk_o equals bclk_pin XOR bclk_inv no more than 3 cycles after the pin settles.
- R9: In slave mode, tx_frm_o and rx_frm_o both equal frm_pin no more than 3 cycles after the pin settles.
- R10: A one-cycle div_load pulse forces tx_frm_o and rx_frm_o to 0 in the next cycle. The bit divider and both frame dividers restart from zero, so every following full period uses the values present at the pulse.
- R11: bclk_oe is 1 while the block is started in master mode, and 0 in slave mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_slave | input | 1 | 1: clocks taken from pins; 0: clocks generated |
| bclk_inv | input | 1 | Inverts the bit clock and swaps the launch and sample edges |
| bit_div | input | DIV_W | Bit clock period minus one, in master clocks |
| tx_div | input | DIV_W | Transmit frame period minus one, in bit clocks |
| rx_div | input | DIV_W | Receive frame period minus one, in bit clocks |
| div_load | input | 1 | One-cycle pulse: restart all dividers with the present fields |
| tx_start | input | 1 | Transmit direction running |
| rx_start | input | 1 | Receive direction running |
| bclk_pin | input | 1 | Bit clock from the pin (slave mode) |
| frm_pin | input | 1 | Frame clock from the pin (slave mode) |
| bclk_o | output | 1 | Bit clock level to drive on the pin |
| bclk_oe | output | 1 | Output enable for the bit and frame clock pins |
| tx_frm_o | output | 1 | Transmit frame clock level |
| rx_frm_o | output | 1 | Receive frame clock level |
| sample_stb | output | 1 | One-cycle strobe at each sample edge |
| launch_stb | output | 1 | One-cycle strobe at each launch edge |

## Verification
The assertions take four things for granted. Every divider field is at least 1. A divider field changes only in the same cycle as a div_load pulse. role_slave does not change while either direction is started. In slave mode, each level on bclk_pin lasts at least as long as the synchronizer latency. The stimulus respects all of these. It draws random divider values from 1 upward, always pulses div_load together with a field change, stops both directions before switching roles, and holds each pin level for four to six clocks. Directed cases add the fastest bit clock (divider 1), a two-slot frame, the common 64-slot frame, and a reload in the middle of a run.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;
   // index of each direction in the frame divider array
   localparam int TX_IDX  = 0;
   localparam int RX_IDX  = 1;
   localparam int NUM_DIR = 2;

   // first count value of the second half of a (limit+1)-long period
   function automatic int unsigned half_count(input int unsigned limit);
      return (limit + 1) / 2;
   endfunction
endpackage

// File: rtl/audio_pin_sync.sv
module audio_pin_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("audio_pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("audio_pin_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/audio_bclk_div.sv
module audio_bclk_div
   import audio_clk_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [DIV_W-1:0] div,
   output logic             raw
);
   localparam int CW = DIV_W + 1;

   logic [DIV_W-1:0] cnt;
   logic [CW-1:0]    half;
   logic [CW-1:0]    cnt_x;

   assign half  = CW'(half_count(32'(div)));
   assign cnt_x = {1'b0, cnt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         raw <= 1'b0;
      end else if (!en || load) begin
         cnt <= '0;
         raw <= 1'b0;
      end else if (cnt >= div) begin
         cnt <= '0;
         raw <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
         if (cnt_x == half - 1'b1) raw <= 1'b0;
      end
   end

   // R2
   bclk_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load) |-> (cnt <= div));
endmodule

// File: rtl/audio_frame_div.sv
module audio_frame_div
   import audio_clk_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic             tick,
   input  logic [DIV_W-1:0] div,
   output logic             lvl
);
   localparam int CW = DIV_W + 1;

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] nxt;
   logic [CW-1:0]    half;
   logic             clr;

   assign clr  = !en || load;
   assign half = CW'(half_count(32'(div)));
   assign nxt  = (cnt >= div) ? '0 : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         lvl <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         lvl <= 1'b0;
      end else if (tick) begin
         cnt <= nxt;
         lvl <= ({1'b0, nxt} >= half);
      end
   end

   // R5
   frame_edge_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl != $past(lvl)) |-> ($past(tick) || $past(clr)));

   // R6
   frame_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load) |-> (cnt <= div));
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
   import audio_clk_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             role_slave,
   input  logic             bclk_inv,
   input  logic [DIV_W-1:0] bit_div,
   input  logic [DIV_W-1:0] tx_div,
   input  logic [DIV_W-1:0] rx_div,
   input  logic             div_load,
   input  logic             tx_start,
   input  logic             rx_start,
   input  logic             bclk_pin,
   input  logic             frm_pin,
   output logic             bclk_o,
   output logic             bclk_oe,
   output logic             tx_frm_o,
   output logic             rx_frm_o,
   output logic             sample_stb,
   output logic             launch_stb
);
   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div_w
      $error("audio_clkgen: DIV_W must lie in 2..16");
   end

   logic             active;
   logic             master_run;
   logic             bclk_raw;
   logic [1:0]       pin_s;
   logic             eff_next;
   logic             eff_q, eff_d;
   logic             act_q, act_d;
   logic             frm_slv_q;
   logic             edge_ok;
   logic [DIV_W-1:0] fdiv    [NUM_DIR];
   logic             frm_lvl [NUM_DIR];

   assign active     = tx_start || rx_start;
   assign master_run = active && !role_slave;

   audio_bclk_div #(.DIV_W(DIV_W)) u_bdiv (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (master_run),
      .load  (div_load),
      .div   (bit_div),
      .raw   (bclk_raw)
   );

   audio_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({frm_pin, bclk_pin}),
      .q     (pin_s)
   );

   // effective bit clock: chosen source, then polarity; idle level when stopped
   assign eff_next = active ? ((role_slave ? pin_s[0] : bclk_raw) ^ bclk_inv)
                            : bclk_inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_q     <= 1'b0;
         eff_d     <= 1'b0;
         act_q     <= 1'b0;
         act_d     <= 1'b0;
         frm_slv_q <= 1'b0;
      end else begin
         eff_q     <= eff_next;
         eff_d     <= eff_q;
         act_q     <= active;
         act_d     <= act_q;
         frm_slv_q <= active && role_slave && pin_s[1];
      end
   end

   assign edge_ok    = act_q && act_d;
   assign sample_stb = edge_ok && eff_q && !eff_d;
   assign launch_stb = edge_ok && !eff_q && eff_d;

   assign fdiv[TX_IDX] = tx_div;
   assign fdiv[RX_IDX] = rx_div;

   for (genvar g = 0; g < NUM_DIR; g++) begin : g_frame
      audio_frame_div #(.DIV_W(DIV_W)) u_fdiv (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (master_run),
         .load  (div_load),
         .tick  (launch_stb),
         .div   (fdiv[g]),
         .lvl   (frm_lvl[g])
      );
   end

   assign bclk_o   = eff_q;
   assign bclk_oe  = act_q && !role_slave;
   assign tx_frm_o = role_slave ? frm_slv_q : frm_lvl[TX_IDX];
   assign rx_frm_o = role_slave ? frm_slv_q : frm_lvl[RX_IDX];

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_start && !rx_start) |=> (!sample_stb && !launch_stb && !bclk_oe));

   // R2
   sample_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   // R4
   launch_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch_stb |=> !launch_stb);

   // R11
   oe_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role_slave && $past(role_slave)) |-> !bclk_oe);
endmodule

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;
   localparam int DIV_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             role_slave = 1'b0;
   logic             bclk_inv = 1'b0;
   logic [DIV_W-1:0] bit_div = 8'd1;
   logic [DIV_W-1:0] tx_div = 8'd1;
   logic [DIV_W-1:0] rx_div = 8'd1;
   logic             div_load = 1'b0;
   logic             tx_start = 1'b0;
   logic             rx_start = 1'b0;
   logic             bclk_pin = 1'b0;
   logic             frm_pin = 1'b0;
   logic             bclk_o, bclk_oe, tx_frm_o, rx_frm_o, sample_stb, launch_stb;

   int  n_chk = 0;
   int  n_bad = 0;
   int  s_total = 0;
   int  l_total = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   audio_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .role_slave(role_slave), .bclk_inv(bclk_inv),
      .bit_div(bit_div), .tx_div(tx_div), .rx_div(rx_div), .div_load(div_load),
      .tx_start(tx_start), .rx_start(rx_start), .bclk_pin(bclk_pin), .frm_pin(frm_pin),
      .bclk_o(bclk_o), .bclk_oe(bclk_oe), .tx_frm_o(tx_frm_o), .rx_frm_o(rx_frm_o),
      .sample_stb(sample_stb), .launch_stb(launch_stb)
   );

   always @(negedge clk) begin
      if (sample_stb) s_total++;
      if (launch_stb) l_total++;
   end

   function automatic int half_of(input int limit);
      return (limit + 1) / 2;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic frm_of(input int which);
      return (which == 0) ? tx_frm_o : rx_frm_o;
   endfunction

   task automatic wait_sample();
      int lim = 0;
      do begin @(negedge clk); lim++; end while (!sample_stb && lim < 3000);
   endtask

   // R2 period, R3/R7 high width
   task automatic measure_bclk(input int d, input bit inv);
      int p = d + 1;
      int exp_hi = inv ? (p - p / 2) : (p / 2);
      wait_sample();
      for (int k = 0; k < 3; k++) begin
         int cyc = 0;
         int hi = 0;
         do begin
            @(negedge clk);
            cyc++;
            if (bclk_o) hi++;
         end while (!sample_stb && cyc < 3000);
         chk("R2", "bit clock period", cyc, p);
         chk(inv ? "R7" : "R3", "bit clock high cycles", hi, exp_hi);
      end
   endtask

   // R5 / R6: launch strobes per frame half
   task automatic measure_frame(input int which, input int div);
      int lim = 0;
      int hi_cnt = 0;
      int lo_cnt = 0;
      logic prev;
      string req = (which == 0) ? "R5" : "R6";
      prev = frm_of(which);
      forever begin
         @(negedge clk);
         lim++;
         if (prev == 1'b0 && frm_of(which) == 1'b1) break;
         prev = frm_of(which);
         if (lim > 20000) break;
      end
      while (lim < 40000) begin
         @(negedge clk); lim++;
         if (frm_of(which) != 1'b1) break;
         if (launch_stb) hi_cnt++;
      end
      while (lim < 40000) begin
         @(negedge clk); lim++;
         if (frm_of(which) != 1'b0) break;
         if (launch_stb) lo_cnt++;
      end
      chk(req, "frame low launches", lo_cnt, half_of(div));
      chk(req, "frame high launches", hi_cnt, (div + 1) - half_of(div));
   endtask

   task automatic idle_check(input bit inv);
      int s0, l0;
      int bad = 0;
      @(negedge clk);
      tx_start = 1'b0;
      rx_start = 1'b0;
      repeat (3) @(negedge clk);
      s0 = s_total;
      l0 = l_total;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (bclk_o != inv || tx_frm_o || rx_frm_o || bclk_oe) bad++;
      end
      chk("R1", "idle outputs off level", bad, 0);
      chk("R1", "idle sample strobes", s_total - s0, 0);
      chk("R1", "idle launch strobes", l_total - l0, 0);
   endtask

   task automatic master_run(input int d, input int t, input int r, input bit inv, input int which_start);
      @(negedge clk);
      role_slave = 1'b0;
      bclk_inv = inv;
      bit_div = DIV_W'(d);
      tx_div = DIV_W'(t);
      rx_div = DIV_W'(r);
      div_load = 1'b1;
      @(negedge clk);
      div_load = 1'b0;
      tx_start = (which_start != 1);
      rx_start = (which_start != 0);
      repeat (2) @(negedge clk);
      chk("R11", "output enable in master run", int'(bclk_oe), 1);
      measure_bclk(d, inv);
      measure_frame(0, t);
      measure_frame(1, r);
      idle_check(inv);
   endtask

   task automatic slave_run(input bit inv, input int nbits);
      int s0, l0;
      int lvl_bad = 0;
      int frm_bad = 0;
      int oe_bad = 0;
      @(negedge clk);
      role_slave = 1'b1;
      bclk_inv = inv;
      bclk_pin = 1'b0;
      frm_pin = 1'b0;
      repeat (4) @(negedge clk);
      tx_start = 1'b1;
      repeat (8) @(negedge clk);
      s0 = s_total;
      l0 = l_total;
      for (int b = 0; b < nbits; b++) begin
         int h = 4 + int'($urandom_range(0, 2));
         bclk_pin = 1'b1;
         repeat (h) @(negedge clk);
         if (bclk_o != (1'b1 ^ inv)) lvl_bad++;
         if (bclk_oe) oe_bad++;
         bclk_pin = 1'b0;
         if (b % 5 == 4) frm_pin = ~frm_pin;
         repeat (h) @(negedge clk);
         if (bclk_o != inv) lvl_bad++;
         if (tx_frm_o != frm_pin || rx_frm_o != frm_pin) frm_bad++;
      end
      repeat (8) @(negedge clk);
      chk("R8", "slave bit clock level mismatches", lvl_bad, 0);
      chk("R8", "slave sample strobes", s_total - s0, nbits);
      chk("R8", "slave launch strobes", l_total - l0, nbits);
      chk("R9", "slave frame level mismatches", frm_bad, 0);
      chk("R11", "output enable in slave mode", oe_bad, 0);
      idle_check(inv);
      @(negedge clk);
      role_slave = 1'b0;
      frm_pin = 1'b0;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "reset bclk_o", int'(bclk_o), 0);
      chk("R1", "reset tx_frm_o", int'(tx_frm_o), 0);
      chk("R1", "reset rx_frm_o", int'(rx_frm_o), 0);
      chk("R1", "reset strobes", int'(sample_stb) + int'(launch_stb), 0);
      chk("R1", "reset bclk_oe", int'(bclk_oe), 0);

      // directed corners: fastest bit clock, two-slot frame, common 64-slot frame
      master_run(1, 1, 63, 1'b0, 2);
      master_run(3, 63, 1, 1'b1, 0);

      // random mix
      for (int it = 0; it < 4; it++) begin
         int d = int'($urandom_range(1, 9));
         int t = int'($urandom_range(1, 40));
         int r = int'($urandom_range(1, 40));
         bit inv = 1'($urandom_range(0, 1));
         int ws = int'($urandom_range(0, 2));
         master_run(d, t, r, inv, ws);
      end

      // R10 reload in the middle of a run
      @(negedge clk);
      role_slave = 1'b0;
      bclk_inv = 1'b0;
      bit_div = 8'd3;
      tx_div = 8'd63;
      rx_div = 8'd63;
      div_load = 1'b1;
      @(negedge clk);
      div_load = 1'b0;
      tx_start = 1'b1;
      repeat (300) @(negedge clk);
      bit_div = 8'd6;
      tx_div = 8'd5;
      rx_div = 8'd7;
      div_load = 1'b1;
      @(negedge clk);
      div_load = 1'b0;
      chk("R10", "tx frame after reload", int'(tx_frm_o), 0);
      chk("R10", "rx frame after reload", int'(rx_frm_o), 0);
      measure_bclk(6, 1'b0);
      measure_frame(0, 5);
      measure_frame(1, 7);
      idle_check(1'b0);

      // slave mode, both polarities
      slave_run(1'b0, 20);
      slave_run(1'b1, 20);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule